// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a direct-mapped table of 2-bit saturating counters and has no target storage, because branch targets are computed later in decode. The fetch stage presents a PC on the lookup side and gets a taken or not-taken guess back in the same cycle. When a branch resolves, the execute stage presents that branch's PC and its real outcome on the update side. The counter in the matching slot then moves one step toward that outcome.

The slot is chosen by the PC bits just above the 2-bit word offset, taken modulo the slot count. Branches whose addresses differ by a multiple of four times the slot count therefore share a counter. The block also keeps a running count of wrong guesses, so a stream of branch events can be scored against the table.

Top module: `brdir_predictor`

## Requirements
- R1: While reset is high, every counter is cleared to 00 and the miss count is cleared to 0. After reset, every lookup predicts not taken.
- R2: The counter code is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A lookup returns taken exactly when the selected counter's upper bit is 1.
- R3: An update with outcome taken moves the slot's counter 00→01→10→11. At 11 the counter stays at 11.
- R4: An update with outcome not taken moves the slot's counter 11→10→01→00. At 00 the counter stays at 00.
- R5: The slot index is PC bits [IDX_W+1:2], with IDX_W = log2(SLOTS). With 8 slots, 0x1C40 selects slot 0, 0x1C44 selects slot 1, 0x1C5C selects slot 7, and 0x1C60 aliases to slot 0.
- R6: When up_valid is low, no counter changes and the miss count holds its value.
- R7: When a lookup and an update select the same slot in the same cycle, the lookup returns the prediction from the counter value before that update.
- R8: On each valid update, miss_count rises by 1, one cycle later, if up_taken differs from the upper bit of the slot's counter before the update. Otherwise miss_count is unchanged.
- R9: With SLOTS = 4, PCs 0x00 and 0x10 share slot 0, and 0x04 selects slot 1.
- R10: PC bits [1:0] do not affect the slot choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the fetch lookup |
| lk_taken | output | 1 | Predicted direction for lk_pc (combinational) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |
| miss_count | output | CNT_W | Number of wrong guesses since reset |

## Verification
The lookup and the update can touch the same counter in the same cycle. Every entry of the stimulus table provokes this on purpose: it drives lk_pc and up_pc with the same address while up_valid is high. The prediction is sampled before the clock edge and must match the counter's value before the update. The miss count is read after the edge and must show whether that earlier guess disagreed with the outcome. An alias address and an address with nonzero low bits stand in for the lookup in some entries, so the same-cycle collision is also seen through the index folding.

// File: rtl/brdir_pkg.sv
package brdir_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the resolved outcome
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_predicts(input ctr_e cur);
    return (cur == CTR_WT) || (cur == CTR_ST);
  endfunction

endpackage

// File: rtl/brdir_index.sv
module brdir_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 3
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int LO = 2;
  localparam int HI = LO + IDX_W - 1;

  assign idx = pc[HI:LO];
endmodule

// File: rtl/brdir_table.sv
module brdir_table
  import brdir_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   rd_idx,
  output ctr_e               rd_state,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_taken,
  output ctr_e               wr_old_state,
  output logic [2*SLOTS-1:0] slot_flat
);
  localparam int FLAT_W = 2 * SLOTS;

  ctr_e slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= CTR_SNT;
      end else if (hit) begin
        slot_q[g] <= ctr_step(slot_q[g], wr_taken);
      end
    end

    assign slot_flat[2*g +: 2] = slot_q[g];
  end

  // reads see the registered value, i.e. the state before any same-cycle write
  assign rd_state     = slot_q[rd_idx];
  assign wr_old_state = slot_q[wr_idx];

  logic [FLAT_W-1:0] unused_flat;
  assign unused_flat = slot_flat;
endmodule

// File: rtl/brdir_miss_ctr.sv
module brdir_miss_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic             guessed_taken,
  input  logic             real_taken,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (upd_en && (guessed_taken != real_taken)) begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/brdir_predictor.sv
module brdir_predictor
  import brdir_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken,
  output logic [CNT_W-1:0] miss_count
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   up_idx;
  ctr_e               lk_state;
  ctr_e               up_old;
  logic [2*SLOTS-1:0] slot_flat;

  brdir_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  brdir_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (
    .pc  (up_pc),
    .idx (up_idx)
  );

  brdir_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst          (rst),
    .rd_idx       (lk_idx),
    .rd_state     (lk_state),
    .wr_en        (up_valid),
    .wr_idx       (up_idx),
    .wr_taken     (up_taken),
    .wr_old_state (up_old),
    .slot_flat    (slot_flat)
  );

  brdir_miss_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk           (clk),
    .rst           (rst),
    .upd_en        (up_valid),
    .guessed_taken (ctr_predicts(up_old)),
    .real_taken    (up_taken),
    .count         (miss_count)
  );

  assign lk_taken = ctr_predicts(lk_state);
endmodule

// File: rtl/brdir_predictor_chk.sv
module brdir_predictor_chk #(
  parameter int SLOTS = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_taken,
  input logic             up_valid,
  input logic [PC_W-1:0]  up_pc,
  input logic             up_taken,
  input logic [CNT_W-1:0] miss_count,
  input logic [2*SLOTS-1:0] slot_flat
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [IDX_W-1:0] lk_i, up_i;
  assign lk_i = lk_pc[IDX_W+1:2];
  assign up_i = up_pc[IDX_W+1:2];

  logic             rst_d;
  logic             pv, pt;
  logic [1:0]       pst;
  logic [IDX_W-1:0] pidx;
  logic [2:0]       before_w, after_w;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    pv    <= up_valid && !rst;
    pt    <= up_taken;
    pidx  <= up_i;
    pst   <= slot_flat[2*up_i +: 2];
  end

  assign before_w = {1'b0, pst};
  assign after_w  = {1'b0, slot_flat[2*pidx +: 2]};

  // R1
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      rst_clear_chk: assert (miss_count == '0 && slot_flat == '0);
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> ($stable(slot_flat) && $stable(miss_count)));

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && lk_i == up_i) |=>
      (miss_count == $past(miss_count) + (($past(lk_taken) != $past(up_taken)) ? CNT_W'(1) : CNT_W'(0))));

  // R3
  taken_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && pt) |-> (after_w >= before_w && after_w <= before_w + 3'd1 && (before_w != 3'd3 || after_w == 3'd3)));

  // R4
  nt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && !pt) |-> (after_w <= before_w && after_w + 3'd1 >= before_w && (before_w != 3'd0 || after_w == 3'd0)));
endmodule

bind brdir_predictor brdir_predictor_chk #(
  .SLOTS(SLOTS), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_pc      (lk_pc),
  .lk_taken   (lk_taken),
  .up_valid   (up_valid),
  .up_pc      (up_pc),
  .up_taken   (up_taken),
  .miss_count (miss_count),
  .slot_flat  (slot_flat)
);

// File: tb/brdir_predictor_bench.sv
module brdir_predictor_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_pc, up_pc;
  logic        up_valid, up_taken;
  logic        lk_taken;
  logic [31:0] miss_count;

  logic [31:0] s4_lk_pc, s4_up_pc;
  logic        s4_up_valid, s4_up_taken, s4_lk_taken;
  logic [31:0] s4_miss;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  brdir_predictor u_brdir_predictor (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .miss_count(miss_count)
  );

  brdir_predictor #(.SLOTS(4)) u_brdir_predictor_s4 (
    .clk(clk), .rst(rst), .lk_pc(s4_lk_pc), .lk_taken(s4_lk_taken),
    .up_valid(s4_up_valid), .up_pc(s4_up_pc), .up_taken(s4_up_taken),
    .miss_count(s4_miss)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        taken;
    logic        exp_pred;
    logic [31:0] exp_miss;
  } vec_t;

  // each entry: lookup and update the same PC in one cycle (R7, R8)
  localparam vec_t VECS [15] = '{
    '{32'h1C40, 1'b1, 1'b0, 32'd1},  // R3 00->01
    '{32'h1C40, 1'b1, 1'b0, 32'd2},  // R3 01->10
    '{32'h1C40, 1'b1, 1'b1, 32'd2},  // R2 R3 10->11
    '{32'h1C40, 1'b1, 1'b1, 32'd2},  // R3 saturate at 11
    '{32'h1C44, 1'b0, 1'b0, 32'd2},  // R4 saturate at 00, R5 slot 1
    '{32'h1C60, 1'b0, 1'b1, 32'd3},  // R5 alias of slot 0, 11->10
    '{32'h1C40, 1'b0, 1'b1, 32'd4},  // R4 10->01
    '{32'h1C42, 1'b1, 1'b0, 32'd5},  // R10 low bits ignored, 01->10
    '{32'h1C44, 1'b1, 1'b0, 32'd6},  // R5 slot 1 separate
    '{32'h1C5C, 1'b1, 1'b0, 32'd7},  // R5 slot 7
    '{32'h1C40, 1'b0, 1'b1, 32'd8},  // R4 10->01
    '{32'h1C40, 1'b0, 1'b0, 32'd8},  // R4 01->00
    '{32'h1C40, 1'b0, 1'b0, 32'd8},  // R4 stay 00
    '{32'h1C44, 1'b1, 1'b0, 32'd9},  // R3 slot 1 01->10
    '{32'h1C44, 1'b0, 1'b1, 32'd10}  // R4 slot 1 10->01
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic upd8(input logic [31:0] pc, input logic t, input logic v);
    @(negedge clk);
    up_pc = pc; up_taken = t; up_valid = v;
    @(posedge clk);
    #2 up_valid = 1'b0;
  endtask

  task automatic look8(input logic [31:0] pc, input logic exp, input string req);
    @(negedge clk);
    lk_pc = pc;
    #2 chk(req, {31'd0, lk_taken}, {31'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; up_valid = 1'b0; up_taken = 1'b0; up_pc = '0; lk_pc = '0;
    s4_up_valid = 1'b0; s4_up_taken = 1'b0; s4_up_pc = '0; s4_lk_pc = '0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1 reset state
    chk("R1 miss after reset", miss_count, 32'd0);
    for (int i = 0; i < 8; i++) look8(32'h1C40 + 32'(4*i), 1'b0, "R1 slot predicts not taken");

    // vector walk
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      lk_pc = VECS[i].pc; up_pc = VECS[i].pc; up_taken = VECS[i].taken; up_valid = 1'b1;
      #2 chk($sformatf("R7 R2 pre-update guess vec %0d", i), {31'd0, lk_taken}, {31'd0, VECS[i].exp_pred});
      @(posedge clk);
      #2 up_valid = 1'b0;
      chk($sformatf("R8 miss count vec %0d", i), miss_count, VECS[i].exp_miss);
    end

    // R6 invalid updates ignored: slot 1 sits at 01
    upd8(32'h1C44, 1'b1, 1'b0);
    upd8(32'h1C44, 1'b1, 1'b0);
    look8(32'h1C44, 1'b0, "R6 slot unchanged by invalid update");
    chk("R6 miss held", miss_count, 32'd10);
    upd8(32'h1C44, 1'b1, 1'b1);
    look8(32'h1C44, 1'b1, "R6 valid update does move slot");

    // R5 untouched slot 4 still cold
    look8(32'h1C50, 1'b0, "R5 slot 4 untouched");

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    chk("R1 miss cleared", miss_count, 32'd0);
    look8(32'h1C44, 1'b0, "R1 slot 1 cleared");

    // R9 four-slot variant
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      s4_up_pc = 32'h0; s4_up_taken = 1'b1; s4_up_valid = 1'b1;
      @(posedge clk);
      #2 s4_up_valid = 1'b0;
    end
    chk("R9 four-slot miss count", s4_miss, 32'd2);
    @(negedge clk); s4_lk_pc = 32'h10;
    #2 chk("R9 0x10 aliases slot 0", {31'd0, s4_lk_taken}, 32'd1);
    @(negedge clk); s4_lk_pc = 32'h04;
    #2 chk("R9 0x04 separate slot", {31'd0, s4_lk_taken}, 32'd0);
    // same address on the 8-slot table is slot 4: still cold
    look8(32'h1C50, 1'b0, "R9 eight-slot does not alias 0x10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule